// File: doc/BRIEF.md
# Multi-Mode UART Baud and Bit-Sampling Generator

This block turns a system clock into the bit timing of a UART receiver. A 16-bit divisor produces a sample tick once every divisor clocks. A second counter groups those ticks into bit periods. A 2-bit oversampling mode picks how many ticks make one bit. It can be the classic 16 ticks, a fast 4 ticks, or a programmable count of up to 256 ticks with a programmable sampling position. The block gives a one-cycle strobe at each bit boundary and another at the sampling point. At the sampling point it also captures the synchronised receive line.

Software programs the block through a byte-wide write port. The two divisor bytes sit behind a latch-access bit in a line-control register, the same way as on a 16550. With that bit clear, writes to the divisor addresses do nothing here. A write to any timing register restarts both counters, so the new timing begins from a clean bit boundary.

Top module: `uart_baud_sampler`

## Requirements
- R1: Mode 0 (and the reserved mode 1) gives a bit period of D×16 clocks. D is the effective divisor.
- R2: Mode 2 gives a bit period of D×4 clocks.
- R3: Mode 3 gives a bit period of D×(C+1) clocks. C is the sample-count register.
- R4: In modes 0, 1 and 2 the mid-bit strobe fires on tick index R/2−1 of each bit, where R is the ticks per bit. It therefore comes D×R/2 clocks after a bit strobe.
- R5: In mode 3 the mid-bit strobe fires on tick index P, where P is the sample-point register. In the other modes the sample-count and sample-point registers have no effect on timing.
- R6: On each mid-bit strobe, rx_bit takes the value of rx_in, seen through a two-stage synchroniser. Between mid-bit strobes rx_bit holds its value.
- R7: Address 0 writes the divisor low byte and address 1 writes the high byte, but only while bit 7 of the line-control register (address 3) is set. With that bit clear, writes to addresses 0 and 1 change nothing.
- R8: A divisor of 0 behaves exactly like a divisor of 1.
- R9: A write to address 4 (mode, bits 1:0), address 5 (sample count), address 6 (sample point), or a gated divisor write restarts the counters. The first bit strobe is then visible D×R+2 clocks after the write edge, and the first mid-bit strobe (m+1)×D+2 clocks after it, where m is the mid-bit tick index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| rx_in | input | 1 | Asynchronous receive line |
| sample_tick | output | 1 | One pulse per divisor period |
| bit_strobe | output | 1 | Pulse at each bit boundary |
| mid_strobe | output | 1 | Pulse at the sampling point |
| rx_bit | output | 1 | Receive line captured at the sampling point |

## Verification
The hardest case to reach is a divisor write made while the latch-access bit is clear. It must leave the timing unchanged, but it also triggers no restart, so nothing visible happens at the moment of the write. Each sweep case therefore places such a stray write between programming the divisor and the final mode write. The case then measures both the latency from that final write and the steady bit period. A stray write that got through would show up as a wrong period. The sweep covers all four mode values against several divisors, including 0 and a value with a nonzero high byte. Mode 3 runs with several sample counts.

// File: rtl/uart_bs_pkg.sv
package uart_bs_pkg;
   typedef enum logic [1:0] {
      HS_X16  = 2'd0,
      HS_RSVD = 2'd1,
      HS_X4   = 2'd2,
      HS_PROG = 2'd3
   } hs_mode_e;

   localparam logic [2:0] ADDR_DIV_LO = 3'd0;
   localparam logic [2:0] ADDR_DIV_HI = 3'd1;
   localparam logic [2:0] ADDR_LCR    = 3'd3;
   localparam logic [2:0] ADDR_MODE   = 3'd4;
   localparam logic [2:0] ADDR_SCOUNT = 3'd5;
   localparam logic [2:0] ADDR_SPOINT = 3'd6;

   localparam int RATIO_X16 = 16;
   localparam int RATIO_X4  = 4;
endpackage

// File: rtl/uart_bs_regs.sv
module uart_bs_regs
   import uart_bs_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DIV_W  = 16,
   parameter int CNT_W  = 8,
   parameter logic [DIV_W-1:0] DIV_RESET = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [2:0]       wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DIV_W-1:0] divisor,
   output hs_mode_e         mode,
   output logic [CNT_W-1:0] scount,
   output logic [CNT_W-1:0] spoint,
   output logic             restart
);
   localparam int LATCH_BIT = DATA_W - 1;

   logic latch_q;
   logic div_lo_wr, div_hi_wr, timing_wr;

   if (DIV_W != 2 * DATA_W) begin : g_bad_div_w
      $error("DIV_W must be twice DATA_W");
   end
   if (CNT_W > DATA_W) begin : g_bad_cnt_w
      $error("CNT_W must not exceed DATA_W");
   end

   assign div_lo_wr = wr_en && latch_q && (wr_addr == ADDR_DIV_LO);
   assign div_hi_wr = wr_en && latch_q && (wr_addr == ADDR_DIV_HI);
   assign timing_wr = div_lo_wr || div_hi_wr ||
                      (wr_en && (wr_addr == ADDR_MODE ||
                                 wr_addr == ADDR_SCOUNT ||
                                 wr_addr == ADDR_SPOINT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= 1'b0;
         divisor <= DIV_RESET;
         mode    <= HS_X16;
         scount  <= '0;
         spoint  <= '0;
         restart <= 1'b0;
      end else begin
         restart <= timing_wr;
         if (wr_en && wr_addr == ADDR_LCR) latch_q <= wr_data[LATCH_BIT];
         if (div_lo_wr) divisor[DATA_W-1:0] <= wr_data;
         if (div_hi_wr) divisor[DIV_W-1:DATA_W] <= wr_data;
         if (wr_en && wr_addr == ADDR_MODE) mode <= hs_mode_e'(wr_data[1:0]);
         if (wr_en && wr_addr == ADDR_SCOUNT) scount <= wr_data[CNT_W-1:0];
         if (wr_en && wr_addr == ADDR_SPOINT) spoint <= wr_data[CNT_W-1:0];
      end
   end

   // R7: a low-byte divisor write without latch access leaves the divisor alone
   a_r7_gated_lo : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_DIV_LO && !latch_q) |=> $stable(divisor));
   // R7: same for the high byte
   a_r7_gated_hi : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_DIV_HI && !latch_q) |=> $stable(divisor));
endmodule

// File: rtl/uart_bs_tickgen.sv
module uart_bs_tickgen #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [DIV_W-1:0] divisor,
   output logic             tick
);
   logic [DIV_W-1:0] eff_div;
   logic [DIV_W-1:0] cnt_q;

   // R8: zero divisor acts as one
   assign eff_div = (divisor == '0) ? DIV_W'(1) : divisor;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         tick  <= 1'b0;
      end else if (restart) begin
         cnt_q <= '0;
         tick  <= 1'b0;
      end else if (cnt_q >= eff_div - DIV_W'(1)) begin
         cnt_q <= '0;
         tick  <= 1'b1;
      end else begin
         cnt_q <= cnt_q + DIV_W'(1);
         tick  <= 1'b0;
      end
   end

   // R8: with an effective divisor above one, ticks never come back to back
   a_r8_tick_spacing : assert property (@(posedge clk) disable iff (!rst_n)
      (tick && eff_div > DIV_W'(1) && !restart) |=> !tick);
   // R9: a restart silences the tick on the next cycle
   a_r9_tick_restart : assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !tick);
endmodule

// File: rtl/uart_bs_bitcnt.sv
module uart_bs_bitcnt
   import uart_bs_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             tick,
   input  hs_mode_e         mode,
   input  logic [CNT_W-1:0] scount,
   input  logic [CNT_W-1:0] spoint,
   input  logic             rx_sync,
   output logic             bit_strobe,
   output logic             mid_strobe,
   output logic             rx_bit
);
   localparam logic [CNT_W-1:0] LAST_X16 = CNT_W'(RATIO_X16 - 1);
   localparam logic [CNT_W-1:0] MID_X16  = CNT_W'(RATIO_X16 / 2 - 1);
   localparam logic [CNT_W-1:0] LAST_X4  = CNT_W'(RATIO_X4 - 1);
   localparam logic [CNT_W-1:0] MID_X4   = CNT_W'(RATIO_X4 / 2 - 1);

   if (RATIO_X16 > (1 << CNT_W)) begin : g_bad_cnt
      $error("CNT_W too small for fixed ratios");
   end

   logic [CNT_W-1:0] idx_q, last_idx, mid_idx;

   always_comb begin
      unique case (mode)
         HS_X4: begin
            last_idx = LAST_X4;
            mid_idx  = MID_X4;
         end
         HS_PROG: begin
            last_idx = scount;
            mid_idx  = spoint;
         end
         default: begin
            last_idx = LAST_X16;
            mid_idx  = MID_X16;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q      <= '0;
         bit_strobe <= 1'b0;
         mid_strobe <= 1'b0;
         rx_bit     <= 1'b1;
      end else if (restart) begin
         idx_q      <= '0;
         bit_strobe <= 1'b0;
         mid_strobe <= 1'b0;
      end else begin
         bit_strobe <= 1'b0;
         mid_strobe <= 1'b0;
         if (tick) begin
            if (idx_q >= last_idx) begin
               idx_q      <= '0;
               bit_strobe <= 1'b1;
            end else begin
               idx_q <= idx_q + CNT_W'(1);
            end
            if (idx_q == mid_idx) begin
               mid_strobe <= 1'b1;
               rx_bit     <= rx_sync;
            end
         end
      end
   end

   // R9: strobes only follow a tick
   a_r9_bit_needs_tick : assert property (@(posedge clk) disable iff (!rst_n)
      bit_strobe |-> $past(tick));
   a_r9_mid_needs_tick : assert property (@(posedge clk) disable iff (!rst_n)
      mid_strobe |-> $past(tick));
   // R6: rx_bit only moves when a mid-bit strobe is raised
   a_r6_rx_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !mid_strobe |-> $stable(rx_bit));
endmodule

// File: rtl/uart_baud_sampler.sv
module uart_baud_sampler
   import uart_bs_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int DIV_W       = 16,
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [2:0]  wr_addr,
   input  logic [7:0]  wr_data,
   input  logic        rx_in,
   output logic        sample_tick,
   output logic        bit_strobe,
   output logic        mid_strobe,
   output logic        rx_bit
);
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 1");
   end
   if (DATA_W != 8) begin : g_bad_data
      $error("port width fixed at 8 bits");
   end

   logic [DIV_W-1:0] divisor;
   hs_mode_e         mode;
   logic [CNT_W-1:0] scount, spoint;
   logic             restart;
   logic [SYNC_STAGES-1:0] sync_q;

   uart_bs_regs #(
      .DATA_W(DATA_W), .DIV_W(DIV_W), .CNT_W(CNT_W)
   ) regs_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .divisor(divisor), .mode(mode),
      .scount(scount), .spoint(spoint), .restart(restart)
   );

   uart_bs_tickgen #(.DIV_W(DIV_W)) tick_i (
      .clk(clk), .rst_n(rst_n), .restart(restart),
      .divisor(divisor), .tick(sample_tick)
   );

   for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[0] <= 1'b1;
            else        sync_q[0] <= rx_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[s] <= 1'b1;
            else        sync_q[s] <= sync_q[s-1];
         end
      end
   end

   uart_bs_bitcnt #(.CNT_W(CNT_W)) bit_i (
      .clk(clk), .rst_n(rst_n), .restart(restart), .tick(sample_tick),
      .mode(mode), .scount(scount), .spoint(spoint),
      .rx_sync(sync_q[SYNC_STAGES-1]),
      .bit_strobe(bit_strobe), .mid_strobe(mid_strobe), .rx_bit(rx_bit)
   );
endmodule

// File: tb/uart_baud_sampler_tb_top.sv
module uart_baud_sampler_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic rx_in = 1'b1;
   logic sample_tick, bit_strobe, mid_strobe, rx_bit;
   int cyc = 0;
   int checks = 0;
   int failures = 0;
   int wcyc = 0;

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   uart_baud_sampler dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rx_in(rx_in), .sample_tick(sample_tick),
      .bit_strobe(bit_strobe), .mid_strobe(mid_strobe), .rx_bit(rx_bit)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk);
      #1 wcyc = cyc;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic run_case(input int mode, input int div, input int sc,
                           input int sp, input logic rxv);
      int eff, ratio, mid, first_bit, second_bit, first_mid, rx_at_mid;
      string tag;
      eff = (div == 0) ? 1 : div;
      if (mode == 2) begin ratio = 4; mid = 1; tag = "R2"; end
      else if (mode == 3) begin ratio = sc + 1; mid = sp; tag = "R3"; end
      else begin ratio = 16; mid = 7; tag = "R1"; end
      rx_in = rxv;
      wr(3'd3, 8'h80);
      wr(3'd0, 8'(div));
      wr(3'd1, 8'(div >> 8));
      wr(3'd3, 8'h00);
      wr(3'd0, 8'(div + 3));   // R7: stray write with latch clear
      wr(3'd1, 8'h01);         // R7: stray high-byte write
      wr(3'd5, 8'(sc));
      wr(3'd6, 8'(sp));
      wr(3'd4, 8'(mode));
      first_bit = -1; second_bit = -1; first_mid = -1; rx_at_mid = -1;
      for (int i = 0; i < 3 * ratio * eff + 20; i++) begin
         @(negedge clk);
         if (mid_strobe && first_mid < 0) begin
            first_mid = cyc; rx_at_mid = int'(rx_bit);
         end
         if (bit_strobe) begin
            if (first_bit < 0) first_bit = cyc;
            else if (second_bit < 0) second_bit = cyc;
         end
      end
      check({tag, " period"}, second_bit - first_bit, ratio * eff);
      check("R9 first bit latency", first_bit - wcyc, ratio * eff + 2);
      check(mode == 3 ? "R5 mid latency" : "R4 mid latency",
            first_mid - wcyc, (mid + 1) * eff + 2);
      check("R6 rx capture", rx_at_mid, int'(rxv));
   endtask

   initial begin
      #100000000;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R9 reset bit_strobe", int'(bit_strobe), 0);
      check("R9 reset mid_strobe", int'(mid_strobe), 0);
      rst_n = 1'b1;
      for (int m = 0; m < 3; m++) begin
         for (int d = 0; d < 4; d++)
            run_case(m == 0 ? 0 : (m == 1 ? 1 : 2), d, 3, 1, d[0]); // R1 R2 R5 ignore regs
      end
      run_case(0, 5, 9, 4, 1'b0);      // R5: sample regs ignored in mode 0
      run_case(2, 257, 0, 0, 1'b1);    // R2 with high byte set
      run_case(0, 0, 0, 0, 1'b0);      // R8 zero divisor
      for (int c = 0; c < 5; c++) begin
         int sc;
         sc = (c == 0) ? 0 : ((1 << c) - 1);
         run_case(3, c + 1, sc, (sc >= 1) ? (sc - 1) >> 1 : 0, c[0]); // R3 R5
      end
      run_case(3, 1, 255, 127, 1'b1);  // R3 largest sample count
      run_case(3, 0, 7, 3, 1'b0);      // R8 in mode 3
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule